// File: doc/BRIEF.md
# Keyboard Device Command Responder

This block sits on the device side of a keyboard link. It takes command bytes written by the host and produces the reply bytes the device sends back. Each accepted byte yields zero, one or two reply bytes. These come out on a valid/ready stream that feeds the controller's receive queue.

The block holds two pieces of state. The first is a scan-enable flag. The second is a flag that marks the next byte as the argument of a two-byte command: set-indicators (0xED) or set-repeat-rate (0xF3). Both flags are driven out as status pins. The input side has a valid/ready handshake. It does not accept a new byte until every reply byte from the previous command has been taken.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After the asynchronous reset, scan_en_o is 1, arg_pending_o is 0, rep_valid_o is 0 and in_ready_o is 1. A reset also cancels a pending argument.
- R2: With no argument pending, input 0xED or 0xF3 produces no reply byte. arg_pending_o is 1 from the next cycle on.
- R3: With an argument pending, any input byte (0x00 to 0xFF) produces exactly one reply, 0xFA. It clears arg_pending_o and leaves scan_en_o unchanged.
- R4: With no argument pending, input 0x00 replies 0xFA, input 0x05 replies 0xFE (resend), and input 0xEE replies 0xEE.
- R5: With no argument pending, each of 0xF4, 0xF5 and 0xF6 replies 0xFA. After 0xF4 and 0xF6, scan_en_o is 1. After 0xF5, scan_en_o is 0.
- R6: With no argument pending, input 0xFF replies two bytes, 0xFA first and then 0xAA. scan_en_o is 1 afterwards.
- R7: With no argument pending, every byte not named in R2, R4, R5 or R6 replies 0xFA alone and leaves scan_en_o unchanged. scan_en_o changes only in the cycle after an accepted byte.
- R8: While rep_valid_o is 1, in_ready_o is 0, so an offered input byte has no effect. While rep_ready_i is 0, the reply byte stays on rep_data_o with rep_valid_o held at 1.
- R9: An input byte is accepted on a clock edge where in_valid_i and in_ready_o are both 1. Its first reply byte is on rep_data_o, with rep_valid_o at 1, right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Host byte offered |
| in_data_i | input | 8 | Host byte |
| in_ready_o | output | 1 | Block can take a host byte |
| rep_valid_o | output | 1 | Reply byte available |
| rep_data_o | output | 8 | Reply byte |
| rep_ready_i | input | 1 | Consumer takes the reply byte |
| scan_en_o | output | 1 | Scan-enable flag |
| arg_pending_o | output | 1 | Next byte is a command argument |

## Verification
The bench sends every byte value to the block in the idle state. It also sends every byte value as the argument of a pending 0xED or 0xF3. Each step is compared with an arithmetic model of the reply table. If the argument path were wrong, a pending 0xFF, 0xF5 or 0xEE would be decoded as a command: the block would give a two-byte reply, change scan_en_o, or echo the byte.

Replies are held back for some cycles before they are taken. During that time the bench offers 0xF5. If the block did not block input while busy, scan_en_o would drop or an extra 0xFA would appear. If it did not hold the reply, the 0xAA after the reset acknowledge would be lost or come early. A reset applied while an argument is pending checks that the pending flag is cleared.

// File: rtl/kbd_resp_pkg.sv
package kbd_resp_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned REPLY_SLOTS = 2;
  localparam int unsigned CNT_W       = $clog2(REPLY_SLOTS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t RSP_ACK     = 8'hFA;
  localparam byte_t RSP_RESEND  = 8'hFE;
  localparam byte_t RSP_POST_OK = 8'hAA;

  localparam byte_t CMD_NOP      = 8'h00;
  localparam byte_t CMD_BAD      = 8'h05;
  localparam byte_t CMD_LEDS     = 8'hED;
  localparam byte_t CMD_ECHO     = 8'hEE;
  localparam byte_t CMD_RATE     = 8'hF3;
  localparam byte_t CMD_SCAN_ON  = 8'hF4;
  localparam byte_t CMD_RST_OFF  = 8'hF5;
  localparam byte_t CMD_RST_ON   = 8'hF6;
  localparam byte_t CMD_RST_FULL = 8'hFF;

  typedef enum logic [1:0] {SCAN_KEEP, SCAN_SET, SCAN_CLR} scan_act_e;

  typedef struct packed {
    logic [CNT_W-1:0] n_rep;
    byte_t            rep1;
    byte_t            rep0;
    scan_act_e        scan;
    logic             pend;
  } dec_t;
endpackage

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_resp_pkg::*;
(
  input  byte_t data_i,
  input  logic  pend_i,
  output dec_t  dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.n_rep = CNT_W'(1);
    dec_o.rep0  = RSP_ACK;
    dec_o.scan  = SCAN_KEEP;
    dec_o.pend  = 1'b0;
    if (!pend_i) begin
      unique case (data_i)
        CMD_LEDS, CMD_RATE: begin
          dec_o.n_rep = '0;
          dec_o.pend  = 1'b1;
        end
        CMD_BAD:     dec_o.rep0 = RSP_RESEND;
        CMD_ECHO:    dec_o.rep0 = CMD_ECHO;
        CMD_SCAN_ON,
        CMD_RST_ON:  dec_o.scan = SCAN_SET;
        CMD_RST_OFF: dec_o.scan = SCAN_CLR;
        CMD_RST_FULL: begin
          dec_o.n_rep = CNT_W'(2);
          dec_o.rep1  = RSP_POST_OK;
          dec_o.scan  = SCAN_SET;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbd_reply_seq.sv
module kbd_reply_seq #(
  parameter int unsigned DW    = 8,
  parameter int unsigned SLOTS = 2,
  localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [CW-1:0]       load_cnt_i,
  input  logic [SLOTS*DW-1:0] load_data_i,
  input  logic                pop_i,
  output logic                valid_o,
  output logic [DW-1:0]       data_o,
  output logic                empty_o
);
  logic [DW-1:0] slot_q [SLOTS];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_cnt_i;
    else if (pop_i)  cnt_q <= cnt_q - CW'(1);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (load_i) slot_q[g] <= load_data_i[g*DW +: DW];
      else if (pop_i) begin
        if (g == SLOTS - 1) slot_q[g] <= '0;
        else                slot_q[g] <= slot_q[(g+1) % SLOTS];
      end
    end
  end

  assign valid_o = (cnt_q != '0);
  assign empty_o = (cnt_q == '0);
  assign data_o  = slot_q[0];
endmodule

// File: rtl/kbd_cmd_responder.sv
module kbd_cmd_responder
  import kbd_resp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       rep_valid_o,
  output logic [7:0] rep_data_o,
  input  logic       rep_ready_i,
  output logic       scan_en_o,
  output logic       arg_pending_o
);
  logic accept, empty;
  dec_t dec;
  logic scan_q, pend_q;

  assign in_ready_o = empty;
  assign accept     = in_valid_i & empty;

  kbd_cmd_decode u_dec (
    .data_i (in_data_i),
    .pend_i (pend_q),
    .dec_o  (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (accept) begin
      pend_q <= dec.pend;
      unique case (dec.scan)
        SCAN_SET: scan_q <= 1'b1;
        SCAN_CLR: scan_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  kbd_reply_seq #(.DW(BYTE_W), .SLOTS(REPLY_SLOTS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_cnt_i  (dec.n_rep),
    .load_data_i ({dec.rep1, dec.rep0}),
    .pop_i       (rep_valid_o & rep_ready_i),
    .valid_o     (rep_valid_o),
    .data_o      (rep_data_o),
    .empty_o     (empty)
  );

  assign scan_en_o     = scan_q;
  assign arg_pending_o = pend_q;
endmodule

// File: rtl/kbd_resp_chk.sv
module kbd_resp_chk
  import kbd_resp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       in_ready_o,
  input logic       rep_valid_o,
  input logic [7:0] rep_data_o,
  input logic       rep_ready_i,
  input logic       scan_en_o,
  input logic       arg_pending_o
);
  logic fire, idle_cmd;
  assign fire     = in_valid_i && in_ready_o;
  assign idle_cmd = fire && !arg_pending_o;

  AST_ARG_NO_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd && (in_data_i == CMD_LEDS || in_data_i == CMD_RATE) |=> arg_pending_o && !rep_valid_o); // R2
  AST_ARG_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && arg_pending_o |=> !arg_pending_o && rep_valid_o && rep_data_o == RSP_ACK && $stable(scan_en_o)); // R3
  AST_ECHO_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd && in_data_i == CMD_ECHO |=> rep_valid_o && rep_data_o == CMD_ECHO); // R4
  AST_SCAN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd && in_data_i == CMD_RST_OFF |=> !scan_en_o && rep_data_o == RSP_ACK); // R5
  AST_FULL_RESET_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_cmd && in_data_i == CMD_RST_FULL |=> scan_en_o && rep_data_o == RSP_ACK); // R6
  AST_SCAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(scan_en_o)); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_o |-> !in_ready_o); // R8
  AST_HOLD_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_o && !rep_ready_i |=> rep_valid_o && $stable(rep_data_o)); // R8
  AST_REPLY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !(idle_cmd && (in_data_i == CMD_LEDS || in_data_i == CMD_RATE)) |=> rep_valid_o); // R9
endmodule

bind kbd_cmd_responder kbd_resp_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_data_i     (in_data_i),
  .in_ready_o    (in_ready_o),
  .rep_valid_o   (rep_valid_o),
  .rep_data_o    (rep_data_o),
  .rep_ready_i   (rep_ready_i),
  .scan_en_o     (scan_en_o),
  .arg_pending_o (arg_pending_o)
);

// File: tb/tb_kbd_cmd_responder.sv
module tb_kbd_cmd_responder;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic rep_ready_i = 1'b0;
  logic in_ready_o, rep_valid_o, scan_en_o, arg_pending_o;
  logic [7:0] rep_data_o;

  always #10 clk_i = ~clk_i;

  kbd_cmd_responder dut (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_ready_o,
    .rep_valid_o, .rep_data_o, .rep_ready_i, .scan_en_o, .arg_pending_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic m_scan = 1'b1;
  logic m_pend = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reply table written from the requirements
  task automatic model(input logic pend, input logic [7:0] b, input logic scan,
                       output int n, output logic [7:0] e0, output logic [7:0] e1,
                       output logic nscan, output logic npend, output string tag);
    n = 1; e0 = 8'hFA; e1 = 8'h00; nscan = scan; npend = 1'b0; tag = "R7";
    if (pend) tag = "R3";
    else case (b)
      8'hED, 8'hF3: begin n = 0; npend = 1'b1; tag = "R2"; end
      8'h00: tag = "R4";
      8'h05: begin e0 = 8'hFE; tag = "R4"; end
      8'hEE: begin e0 = 8'hEE; tag = "R4"; end
      8'hF4, 8'hF6: begin nscan = 1'b1; tag = "R5"; end
      8'hF5: begin nscan = 1'b0; tag = "R5"; end
      8'hFF: begin n = 2; e1 = 8'hAA; nscan = 1'b1; tag = "R6"; end
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] b, input int stall);
    int n; logic [7:0] e0, e1; logic nscan, npend; string tag;
    model(m_pend, b, m_scan, n, e0, e1, nscan, npend, tag);
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R8", "ready when drained", in_ready_o, 1);
    in_valid_i = 1'b1; in_data_i = b;
    @(posedge clk_i); @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(rep_valid_o == (n > 0), "R9", "valid after accept", rep_valid_o, int'(n > 0));
    chk(arg_pending_o == npend, tag, "pending flag", arg_pending_o, npend);
    chk(scan_en_o == nscan, tag, "scan flag", scan_en_o, nscan);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = (k == 0) ? e0 : e1;
      for (int s = 0; s < stall; s++) begin
        chk(rep_valid_o && rep_data_o == e, "R8", "held reply", rep_data_o, e);
        chk(in_ready_o == 1'b0, "R8", "ready while busy", in_ready_o, 0);
        in_valid_i = 1'b1; in_data_i = 8'hF5;  // must be ignored
        @(posedge clk_i); @(negedge clk_i);
      end
      chk(rep_valid_o == 1'b1, tag, "reply valid", rep_valid_o, 1);
      chk(rep_data_o == e, tag, "reply byte", rep_data_o, e);
      rep_ready_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      rep_ready_i = 1'b0; in_valid_i = 1'b0;
    end
    chk(rep_valid_o == 1'b0, tag, "no extra reply", rep_valid_o, 0);
    chk(scan_en_o == nscan, "R8", "scan after busy input", scan_en_o, nscan);
    m_scan = nscan; m_pend = npend;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk(scan_en_o == 1'b1, "R1", "reset scan", scan_en_o, 1);
    chk(arg_pending_o == 1'b0, "R1", "reset pending", arg_pending_o, 0);
    chk(rep_valid_o == 1'b0, "R1", "reset valid", rep_valid_o, 0);
    chk(in_ready_o == 1'b1, "R1", "reset ready", in_ready_o, 1);
    rst_ni = 1'b1;
    m_scan = 1'b1; m_pend = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    do_reset();
    // idle sweep over every byte value
    for (int i = 0; i < 256; i++) begin
      send(8'(i), (i % 3 == 0) ? 2 : 0);
      if (m_pend) send(8'(i ^ 8'h5A), 1);
    end
    // argument sweep: every value behind a pending two-byte command
    for (int a = 0; a < 256; a++) begin
      if (a % 4 == 0) send(8'hF5, 0);
      send((a % 2 == 0) ? 8'hED : 8'hF3, 0);
      send(8'(a), a % 2);
    end
    // reset cancels a pending argument (R1)
    send(8'hF5, 0);
    send(8'hED, 0);
    do_reset();
    send(8'hEE, 3);
    send(8'hFF, 4);
    finish_run();
  end
endmodule